// File: doc/BRIEF.md
# SPI flash status-register write controller

This block is the slave-side command logic of a serial flash that looks after the status register. A host talks to it over a four-wire serial link: active-low select, serial clock, serial data in and serial data out. The block samples the link with its own system clock. After select falls it collects an 8-bit command code. It keeps a write enable latch, and it takes one data byte for the status register. When select rises it decides whether that byte may be committed.

A committed write starts a self-timed busy period. Its length is a number of system clocks set by a parameter. During that period a busy flag reads as 1 and further write-type commands are dropped. When the period ends, the busy flag clears and the write enable latch clears with it. The host reads the register with a read-status command, so it can poll the busy flag while the write is running. A hardware lock is formed by the register's lock bit together with the write-protect pin. While the lock holds, no status writes are accepted.

Top module: `sr_write_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00 and the data output enable is low.
- R2: Command 0x06 (enable-write) with exactly 8 clocked bits before select rises sets the enable latch, which reads as status bit 1.
- R3: Command 0x01 followed by one data byte, MSB first, writes data bit 7 to status bit 7 (lock bit) and data bits 4..2 to status bits 4..2; status bits 6 and 5 always read 0 and data bits 6, 5, 1, 0 are not stored.
- R4: A 0x01 command issued while the enable latch is 0 leaves the status byte unchanged.
- R5: A 0x01 command is committed only when select rises after exactly 16 clocked bits; 15 or 17 bits leave the status byte unchanged.
- R6: A committed write sets the busy flag (status bit 0) for WRITE_CYCLES system clocks; when the busy flag clears, the enable latch clears at the same moment.
- R7: Command 0x05 shifts out the live status byte MSB first, with each bit driven after a falling serial clock, and repeats that byte for as long as select stays low, including while busy.
- R8: While the lock bit is 1 and wp_n is 0, a 0x01 command is not committed; with wp_n at 1 it is committed normally.
- R9: While the busy flag is 1, commands 0x06 and 0x01 are ignored and status bits 7..2 do not change.
- R10: The data output enable is high only while select is low and is low while select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock (mode 0 or 3) |
| mosi | input | 1 | Serial data in, sampled on rising sclk |
| wp_n | input | 1 | Write-protect pin, low asserts the lock when the lock bit is set |
| sdo | output | 1 | Serial data out, changed after falling sclk |
| sdo_en | output | 1 | Output enable for sdo (high impedance when low) |

## Verification
Two functions can act in the same system-clock cycle: the self-timed countdown expiring, and a select edge or serial clock edge from the host. When the countdown expires it clears both the busy flag and the enable latch. The bench provokes the overlap by issuing a full, well-formed write and a status read while the countdown is still running. It then judges at the serial output that the busy-time write was dropped, that busy and enable read 1 during the period, and that both read 0 afterwards. A status read is also started right after a commit, to show that polling returns the live busy flag and repeats the byte.

// File: rtl/sr_write_pkg.sv
package sr_write_pkg;

    localparam int OP_W = 8;

    localparam logic [OP_W-1:0] OP_WREN = 8'h06;
    localparam logic [OP_W-1:0] OP_WRSR = 8'h01;
    localparam logic [OP_W-1:0] OP_RDSR = 8'h05;

    // Bits clocked in for a complete status write: opcode plus one data byte
    localparam int WRSR_BITS = 2 * OP_W;
    localparam int CNT_W     = $clog2(WRSR_BITS) + 1;

    typedef struct packed {
        logic [CNT_W-1:0] bits;
        logic [OP_W-1:0]  shreg;
        logic [OP_W-1:0]  opcode;
        logic [2:0]       rd_idx;
        logic             sdo;
        logic             wel;
        logic             srwd;
        logic [2:0]       bp;
    } ctrl_t;

endpackage

// File: rtl/sr_sync.sv
module sr_sync #(
    parameter int            W      = 4,
    parameter int            STAGES = 2,
    parameter logic [W-1:0]  INIT   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] pipe_d [STAGES+1];
    logic [W-1:0] pipe_q [STAGES+1];

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i <= STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i <= STAGES; i++) begin
                pipe_q[i] <= INIT;
            end
        end else begin
            for (int i = 0; i <= STAGES; i++) begin
                pipe_q[i] <= pipe_d[i];
            end
        end
    end

    for (genvar b = 0; b < W; b++) begin : g_edge
        assign lvl[b]  = pipe_q[STAGES-1][b];
        assign rise[b] = pipe_q[STAGES-1][b] & ~pipe_q[STAGES][b];
        assign fall[b] = ~pipe_q[STAGES-1][b] & pipe_q[STAGES][b];
    end
endmodule

// File: rtl/sr_timer.sv
module sr_timer #(
    parameter int CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          busy_d, busy_q;

    always_comb begin
        cnt_d  = cnt_q;
        busy_d = busy_q;
        done   = 1'b0;
        if (busy_q) begin
            if (cnt_q == '0) begin
                busy_d = 1'b0;
                done   = 1'b1;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end else if (start) begin
            busy_d = 1'b1;
            cnt_d  = CW'(CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            busy_q <= busy_d;
        end
    end

    assign busy = busy_q;
endmodule

// File: rtl/sr_write_ctrl.sv
module sr_write_ctrl
    import sr_write_pkg::*;
#(
    parameter int WRITE_CYCLES = 50,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    input  logic wp_n,
    output logic sdo,
    output logic sdo_en
);
    localparam int PIN_W = 4;
    localparam int P_CS  = 3;
    localparam int P_SCK = 2;
    localparam int P_DI  = 1;
    localparam int P_WP  = 0;

    logic [PIN_W-1:0] pin_lvl, pin_rise, pin_fall;

    sr_sync #(
        .W      (PIN_W),
        .STAGES (SYNC_STAGES),
        .INIT   (4'b1001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cs_n, sclk, mosi, wp_n}),
        .lvl   (pin_lvl),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    logic cs_lvl, cs_rise, cs_fall, sck_rise, sck_fall, di_lvl, wp_lvl;
    assign cs_lvl   = pin_lvl[P_CS];
    assign cs_rise  = pin_rise[P_CS];
    assign cs_fall  = pin_fall[P_CS];
    assign sck_rise = pin_rise[P_SCK];
    assign sck_fall = pin_fall[P_SCK];
    assign di_lvl   = pin_lvl[P_DI];
    assign wp_lvl   = pin_lvl[P_WP];

    logic busy, done, start;

    sr_timer #(
        .CYCLES (WRITE_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done)
    );

    ctrl_t state_d, state_q;
    logic [7:0] stat;
    logic       hw_lock;

    assign stat    = {state_q.srwd, 2'b00, state_q.bp, state_q.wel, busy};
    assign hw_lock = state_q.srwd & ~wp_lvl;

    always_comb begin
        state_d = state_q;
        start   = 1'b0;

        if (cs_fall) begin
            state_d.bits   = '0;
            state_d.opcode = '0;
            state_d.rd_idx = '0;
        end else if (!cs_lvl) begin
            if (sck_rise) begin
                state_d.shreg = {state_q.shreg[OP_W-2:0], di_lvl};
                if (state_q.bits != {CNT_W{1'b1}}) begin
                    state_d.bits = state_q.bits + 1'b1;
                end
                if (state_q.bits == CNT_W'(OP_W - 1)) begin
                    state_d.opcode = {state_q.shreg[OP_W-2:0], di_lvl};
                    state_d.rd_idx = '0;
                end
            end
            if (sck_fall && state_q.bits >= CNT_W'(OP_W) && state_q.opcode == OP_RDSR) begin
                state_d.sdo    = stat[3'd7 - state_q.rd_idx];
                state_d.rd_idx = state_q.rd_idx + 1'b1;
            end
        end

        if (cs_rise && !busy) begin
            if (state_q.opcode == OP_WREN && state_q.bits == CNT_W'(OP_W)) begin
                state_d.wel = 1'b1;
            end else if (state_q.opcode == OP_WRSR && state_q.bits == CNT_W'(WRSR_BITS)
                         && state_q.wel && !hw_lock) begin
                state_d.srwd = state_q.shreg[7];
                state_d.bp   = state_q.shreg[4:2];
                start        = 1'b1;
            end
        end

        if (done) begin
            state_d.wel = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sdo    = state_q.sdo;
    assign sdo_en = ~cs_lvl;
endmodule

// File: rtl/sr_write_chk.sv
module sr_write_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sdo_en,
    input logic       wip,
    input logic       wel,
    input logic [5:0] prot
);
    // R6
    wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel);

    // R4
    commit_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> wel);

    // R9
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wip |=> $stable(prot));

    // R9
    wel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> !wip);

    // R10
    sdo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_en);
endmodule

bind sr_write_ctrl sr_write_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .sdo_en (sdo_en),
    .wip    (stat[0]),
    .wel    (stat[1]),
    .prot   (stat[7:2])
);

// File: tb/sr_write_ctrl_test.sv
module sr_write_ctrl_test;
    localparam int WCYC = 1000;
    localparam int H    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, wp_n = 1'b1;
    logic sdo, sdo_en;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sr_write_ctrl #(.WRITE_CYCLES(WCYC)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .mosi(mosi), .wp_n(wp_n), .sdo(sdo), .sdo_en(sdo_en)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bit(input logic b);
        mosi = b;
        idle(H);
        sclk = 1'b1;
        idle(H);
        sclk = 1'b0;
    endtask

    task automatic xfer(input logic [31:0] v, input int n);
        cs_n = 1'b0;
        idle(H);
        for (int i = n - 1; i >= 0; i--) spi_bit(v[i]);
        idle(H);
        cs_n = 1'b1;
        idle(12);
    endtask

    task automatic rd(output logic [7:0] b0, output logic [7:0] b1);
        logic [15:0] v;
        v = '0;
        cs_n = 1'b0;
        idle(H);
        for (int i = 7; i >= 0; i--) spi_bit(OPC_RD[i]);
        for (int i = 0; i < 16; i++) begin
            idle(H);
            v = {v[14:0], sdo};
            sclk = 1'b1;
            idle(H);
            sclk = 1'b0;
        end
        chk("R10 enable while selected", {7'd0, sdo_en}, 8'h01);
        idle(H);
        cs_n = 1'b1;
        idle(12);
        b0 = v[15:8];
        b1 = v[7:0];
    endtask

    localparam logic [7:0] OPC_RD = 8'h05;

    task automatic t_reset;
        logic [7:0] a, b;
        chk("R10 enable off while deselected", {7'd0, sdo_en}, 8'h00);
        rd(a, b);
        chk("R1 reset status", a, 8'h00);
    endtask

    task automatic t_no_wel;
        logic [7:0] a, b;
        xfer(32'h01FF, 16);
        rd(a, b);
        chk("R4 write without enable", a, 8'h00);
    endtask

    task automatic t_wren;
        logic [7:0] a, b;
        xfer(32'h06, 8);
        rd(a, b);
        chk("R2 enable latch set", a, 8'h02);
    endtask

    task automatic t_bitcount;
        logic [7:0] a, b;
        xfer(32'h01FC >> 1, 15);
        rd(a, b);
        chk("R5 15-bit write dropped", a, 8'h02);
        xfer((32'h01FC << 1) | 32'h1, 17);
        rd(a, b);
        chk("R5 17-bit write dropped", a, 8'h02);
    endtask

    task automatic t_write;
        logic [7:0] a, b;
        xfer(32'h01FF, 16);
        rd(a, b);
        chk("R6 busy after commit", a, 8'h9F);
        chk("R7 byte repeats", b, 8'h9F);
        idle(WCYC + 100);
        rd(a, b);
        chk("R3 stored bits, R6 enable cleared", a, 8'h9C);
        chk("R3 bits 6 and 5 read zero", a & 8'h60, 8'h00);
    endtask

    task automatic t_hpm;
        logic [7:0] a, b;
        wp_n = 1'b0;
        idle(4);
        xfer(32'h06, 8);
        xfer(32'h0100, 16);
        idle(WCYC + 100);
        rd(a, b);
        chk("R8 locked write ignored", a, 8'h9E);
        wp_n = 1'b1;
        idle(4);
        xfer(32'h0100, 16);
        rd(a, b);
        chk("R8 unlocked write busy", a, 8'h03);
        idle(WCYC + 100);
        rd(a, b);
        chk("R8 unlocked write stored", a, 8'h00);
    endtask

    task automatic t_busy;
        logic [7:0] a, b;
        xfer(32'h06, 8);
        xfer(32'h0110, 16);
        xfer(32'h011C, 16);
        rd(a, b);
        chk("R9 write during busy ignored", a, 8'h13);
        chk("R7 live read while busy", b, 8'h13);
        idle(WCYC + 100);
        rd(a, b);
        chk("R9 final status", a, 8'h10);
    endtask

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(5);
        t_reset();
        t_no_wel();
        t_wren();
        t_bitcount();
        t_write();
        t_hpm();
        t_busy();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=expired expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule